// File: doc/BRIEF.md
# Receive Frame FIFO with Whole-Frame Admission

This block buffers received CAN and CAN FD frames between the protocol engine and a register-mapped reader. Every frame enters as a run of 32-bit words and starts with a format word. The format word gives the number of words that follow it, and it carries a flag marking the frame as FD. The reader pulls words out one at a time. It uses the format word to learn how many more words belong to the same frame.

Admission is decided once per frame, when its format word arrives. The block compares the full frame length with the free space that the reader has not yet claimed back. If the frame fits, that space is set aside and the words are written one by one. The reader sees none of them until the last word has been stored. If the frame does not fit, every word of it is thrown away and a sticky overrun status flag is raised. The interrupt flag follows from the status flag one cycle later.

Software must clear the two flags in a fixed order. First it clears the status flag with a command pulse, and then it clears the interrupt flag. In the interrupt flag, a clear request takes priority over the set input in the same cycle. A clear issued while the status flag is still high therefore takes effect, but the interrupt flag comes back on the next cycle.

Top module: `rxf_frame_fifo`

## Requirements
- R1: A stored format word is handed to the reader unchanged and ahead of its payload. Bits [4:0] hold N, the number of words that follow it. Bit 9 is the FD flag, which is carried through and not interpreted. Bits [31:24] and the other bits are free for the writer.
- R2: `rx_words_o` equals the number of committed words not yet read. `rxne_o` is high exactly when that number is non-zero.
- R3: A frame of 1+N words is accepted if and only if 1+N is no greater than DEPTH minus the committed unread words. While an accepted frame is being written, `rx_words_o` does not change. It rises by 1+N in the cycle after the last word.
- R4: A frame that does not fit is discarded whole, including all of its later words. `dor_o` is high in the cycle after its format word.
- R5: `doi_o` sets in the cycle after `dor_o` is seen high. It stays set until it is cleared.
- R6: Only `clr_dor_i` or soft reset clears `dor_o`. A new overrun in the same cycle as `clr_dor_i` leaves `dor_o` set.
- R7: `clr_doi_i` forces `doi_o` low in the next cycle, even while the set input is active. If `dor_o` is still high, `doi_o` re-arms one cycle later. Clearing `dor_o` first and then `doi_o` leaves `doi_o` low.
- R8: `rd_data_o` shows the oldest committed word, and each `rd_strobe_i` consumes one word. While the FIFO is empty, `rd_data_o` is zero and a strobe changes nothing.
- R9: A format word that arrives while a frame is still incomplete abandons that frame. None of its words become visible, its space is reclaimed, and the new frame is judged for admission.
- R10: Words written with `wr_first_i` low while no frame is open are ignored.
- R11: `soft_rst_i` empties the FIFO and clears `dor_o` and `doi_o` on the next edge.
- R12: A frame longer than DEPTH words is always rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous flush of contents and flags |
| wr_valid_i | input | 1 | Write word valid, from the protocol side |
| wr_first_i | input | 1 | Current write word is a format word |
| wr_data_i | input | 32 | Write word |
| rd_strobe_i | input | 1 | Consume the word shown on rd_data_o |
| rd_data_o | output | 32 | Oldest committed word, or zero when empty |
| rxne_o | output | 1 | At least one committed word is readable |
| rx_words_o | output | $clog2(DEPTH)+1 | Committed unread word count |
| clr_dor_i | input | 1 | Command: clear the overrun status flag |
| clr_doi_i | input | 1 | Clear the overrun interrupt flag |
| dor_o | output | 1 | Overrun status flag |
| doi_o | output | 1 | Overrun interrupt flag |

## Verification
The checker watches the flag rules on every cycle. It confirms that the interrupt flag rises only after the status flag, that a clear always wins, that the status flag falls only on a command or a flush, and that a rejection sets the status flag. It also confirms that an empty read returns zero and moves nothing, that the level never exceeds DEPTH or grows without a write, and that a flush empties the block. Whether a frame is admitted at a given fill level, whether words come out in the right order, and whether partial frames stay hidden can only be shown by the bench's scenarios. The bench sweeps every fill level against every frame length around the capacity limit. It also runs the ordered clear sequence, an abandoned partial frame, and stray writes outside a frame.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int WORD_W     = 32;
    localparam int FMT_LEN_LSB = 0;
    localparam int FMT_LEN_W  = 5;
    localparam int FMT_FD_BIT = 9;

    // Number of words that follow the format word
    function automatic logic [FMT_LEN_W-1:0] fmt_len(input logic [WORD_W-1:0] w);
        return w[FMT_LEN_LSB +: FMT_LEN_W];
    endfunction
endpackage

// File: rtl/rxf_admit.sv
module rxf_admit
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = AW + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              soft_rst_i,
    input  logic              wr_valid_i,
    input  logic              wr_first_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic [CW-1:0]     rd_ptr_i,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    output logic [CW-1:0]     commit_ptr_o,
    output logic              ovr_evt_o
);
    localparam int CMP_W = ((CW > FMT_LEN_W + 1) ? CW : FMT_LEN_W + 1) + 1;

    typedef struct packed {
        logic [CW-1:0]        wr_ptr;
        logic [CW-1:0]        commit_ptr;
        logic [FMT_LEN_W-1:0] remain;
        logic                 active;
    } admit_t;

    admit_t st_d, st_q;
    logic [CW-1:0]        used;
    logic [CMP_W-1:0]     free_w, need_w;
    logic [FMT_LEN_W-1:0] len;

    always_comb begin
        st_d        = st_q;
        mem_we_o    = 1'b0;
        mem_addr_o  = st_q.wr_ptr[AW-1:0];
        mem_wdata_o = wr_data_i;
        ovr_evt_o   = 1'b0;
        len         = fmt_len(wr_data_i);
        used        = st_q.commit_ptr - rd_ptr_i;
        free_w      = CMP_W'(DEPTH) - CMP_W'(used);
        need_w      = CMP_W'(len) + CMP_W'(1);

        if (soft_rst_i) begin
            st_d = '0;
        end else if (wr_valid_i && wr_first_i) begin
            // A new frame always starts at the commit point; an open frame is dropped
            if (need_w <= free_w) begin
                mem_we_o   = 1'b1;
                mem_addr_o = st_q.commit_ptr[AW-1:0];
                st_d.wr_ptr = st_q.commit_ptr + CW'(1);
                if (len == '0) begin
                    st_d.commit_ptr = st_q.commit_ptr + CW'(1);
                    st_d.active     = 1'b0;
                    st_d.remain     = '0;
                end else begin
                    st_d.active = 1'b1;
                    st_d.remain = len;
                end
            end else begin
                ovr_evt_o   = 1'b1;
                st_d.active = 1'b0;
                st_d.remain = '0;
                st_d.wr_ptr = st_q.commit_ptr;
            end
        end else if (wr_valid_i && st_q.active) begin
            mem_we_o    = 1'b1;
            mem_addr_o  = st_q.wr_ptr[AW-1:0];
            st_d.wr_ptr = st_q.wr_ptr + CW'(1);
            st_d.remain = st_q.remain - FMT_LEN_W'(1);
            if (st_q.remain == FMT_LEN_W'(1)) begin
                st_d.commit_ptr = st_q.wr_ptr + CW'(1);
                st_d.active     = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign commit_ptr_o = st_q.commit_ptr;
endmodule

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = AW + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              soft_rst_i,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [CW-1:0]     commit_ptr_i,
    input  logic              rd_strobe_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic [CW-1:0]     rd_ptr_o,
    output logic [CW-1:0]     level_o,
    output logic              rxne_o
);
    typedef struct packed {
        logic [CW-1:0] rd_ptr;
    } rd_t;

    rd_t               st_d, st_q;
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic              empty;

    always_comb begin
        st_d    = st_q;
        level_o = commit_ptr_i - st_q.rd_ptr;
        empty   = (level_o == '0);
        rd_data_o = empty ? '0 : mem_q[st_q.rd_ptr[AW-1:0]];
        if (soft_rst_i)                 st_d.rd_ptr = '0;
        else if (rd_strobe_i && !empty) st_d.rd_ptr = st_q.rd_ptr + CW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_ff @(posedge clk_i) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rd_ptr_o = st_q.rd_ptr;
    assign rxne_o   = !empty;
endmodule

// File: rtl/rxf_ovr_flags.sv
module rxf_ovr_flags (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic soft_rst_i,
    input  logic ovr_evt_i,
    input  logic clr_dor_i,
    input  logic clr_doi_i,
    output logic dor_o,
    output logic doi_o
);
    typedef struct packed {
        logic dor;
        logic doi;
    } flags_t;

    flags_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Status: a fresh overrun outranks the clear command
        if (soft_rst_i)     st_d.dor = 1'b0;
        else if (ovr_evt_i) st_d.dor = 1'b1;
        else if (clr_dor_i) st_d.dor = 1'b0;
        // Interrupt: set from the registered status level, clear outranks set
        if (soft_rst_i || clr_doi_i) st_d.doi = 1'b0;
        else if (st_q.dor)           st_d.doi = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign dor_o = st_q.dor;
    assign doi_o = st_q.doi;
endmodule

// File: rtl/rxf_frame_fifo.sv
module rxf_frame_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   soft_rst_i,
    input  logic                   wr_valid_i,
    input  logic                   wr_first_i,
    input  logic [31:0]            wr_data_i,
    input  logic                   rd_strobe_i,
    output logic [31:0]            rd_data_o,
    output logic                   rxne_o,
    output logic [$clog2(DEPTH):0] rx_words_o,
    input  logic                   clr_dor_i,
    input  logic                   clr_doi_i,
    output logic                   dor_o,
    output logic                   doi_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic              mem_we;
    logic [AW-1:0]     mem_addr;
    logic [WORD_W-1:0] mem_wdata;
    logic [CW-1:0]     commit_ptr, rd_ptr;
    logic              ovr_evt;

    rxf_admit #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_admit (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .soft_rst_i   (soft_rst_i),
        .wr_valid_i   (wr_valid_i),
        .wr_first_i   (wr_first_i),
        .wr_data_i    (wr_data_i),
        .rd_ptr_i     (rd_ptr),
        .mem_we_o     (mem_we),
        .mem_addr_o   (mem_addr),
        .mem_wdata_o  (mem_wdata),
        .commit_ptr_o (commit_ptr),
        .ovr_evt_o    (ovr_evt)
    );

    rxf_store #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_store (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .soft_rst_i   (soft_rst_i),
        .we_i         (mem_we),
        .waddr_i      (mem_addr),
        .wdata_i      (mem_wdata),
        .commit_ptr_i (commit_ptr),
        .rd_strobe_i  (rd_strobe_i),
        .rd_data_o    (rd_data_o),
        .rd_ptr_o     (rd_ptr),
        .level_o      (rx_words_o),
        .rxne_o       (rxne_o)
    );

    rxf_ovr_flags u_flags (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .soft_rst_i (soft_rst_i),
        .ovr_evt_i  (ovr_evt),
        .clr_dor_i  (clr_dor_i),
        .clr_doi_i  (clr_doi_i),
        .dor_o      (dor_o),
        .doi_o      (doi_o)
    );
endmodule

// File: rtl/rxf_frame_fifo_chk.sv
module rxf_frame_fifo_chk #(
    parameter int DEPTH = 16
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   soft_rst_i,
    input logic                   wr_valid_i,
    input logic                   rd_strobe_i,
    input logic [31:0]            rd_data_o,
    input logic                   rxne_o,
    input logic [$clog2(DEPTH):0] rx_words_o,
    input logic                   clr_dor_i,
    input logic                   clr_doi_i,
    input logic                   dor_o,
    input logic                   doi_o,
    input logic                   ovr_evt
);
    localparam int CW = $clog2(DEPTH) + 1;

    // R8
    empty_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rxne_o |-> rd_data_o == '0);

    // R8
    empty_pop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rxne_o && rd_strobe_i && !wr_valid_i && !soft_rst_i) |=> rx_words_o == '0);

    // R2
    level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_words_o <= CW'(DEPTH));

    // R3
    no_write_no_growth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_valid_i |=> rx_words_o <= $past(rx_words_o));

    // R4
    dor_on_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovr_evt && !soft_rst_i) |=> dor_o);

    // R5
    doi_after_dor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(doi_o) |-> $past(dor_o));

    // R6
    dor_fall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(dor_o) |-> $past(clr_dor_i || soft_rst_i));

    // R7
    doi_clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_doi_i |=> !doi_o);

    // R11
    flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_rst_i |=> (rx_words_o == '0 && !dor_o && !doi_o));
endmodule

bind rxf_frame_fifo rxf_frame_fifo_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_rxf_frame_fifo.sv
`timescale 1ns/1ps
module sim_rxf_frame_fifo;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_rst = 1'b0;
    logic          wr_valid = 1'b0;
    logic          wr_first = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          rd_strobe = 1'b0;
    logic [31:0]   rd_data;
    logic          rxne;
    logic [CW-1:0] rx_words;
    logic          clr_dor = 1'b0;
    logic          clr_doi = 1'b0;
    logic          dor, doi;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rxf_frame_fifo #(.DEPTH(DEPTH)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
        .wr_valid_i(wr_valid), .wr_first_i(wr_first), .wr_data_i(wr_data),
        .rd_strobe_i(rd_strobe), .rd_data_o(rd_data), .rxne_o(rxne),
        .rx_words_o(rx_words), .clr_dor_i(clr_dor), .clr_doi_i(clr_doi),
        .dor_o(dor), .doi_o(doi)
    );

    function automatic logic [31:0] fmt(input int tag, input bit fd, input int n);
        return {8'(tag), 14'h0, fd, 4'h0, 5'(n)};
    endfunction

    function automatic logic [31:0] pw(input int tag, input int idx);
        return {8'(tag), 8'hA5, 16'(idx)};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input bit first, input logic [31:0] d);
        wr_valid = 1'b1; wr_first = first; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0; wr_first = 1'b0;
    endtask

    task automatic wr_frame(input int tag, input int n);
        wr(1'b1, fmt(tag, 1'b0, n));
        for (int i = 0; i < n; i++) wr(1'b0, pw(tag, i));
    endtask

    task automatic rd(input string req, input logic [31:0] exp);
        chk(req, rd_data, exp);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic flush();
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk("R2 reset rxne", rxne, 0);
        chk("R2 reset level", rx_words, 0);
        chk("R8 reset data", rd_data, 0);
        chk("R6 reset dor", dor, 0);
        chk("R5 reset doi", doi, 0);

        // R3 R4 R12 R1 R8: sweep fill level against frame length
        for (int f = 0; f <= DEPTH; f++) begin
            for (int n = 0; n <= DEPTH + 1; n++) begin
                bit acc;
                flush();
                if (f > 0) wr_frame(1, f - 1);
                chk("R2 fill level", rx_words, f);
                acc = (1 + n <= DEPTH - f);
                wr(1'b1, fmt(2, n[0], n));
                if (n > 0) chk("R3 hidden partial", rx_words, f);
                for (int i = 0; i < n; i++) wr(1'b0, pw(2, i));
                chk("R3 admit level", rx_words, acc ? f + 1 + n : f);
                chk("R4 overrun flag", dor, !acc);
                chk("R2 rxne", rxne, (f > 0) || acc);
                if (f > 0) begin
                    rd("R1 fill fmt", fmt(1, 1'b0, f - 1));
                    for (int i = 0; i < f - 1; i++) rd("R8 fill payload", pw(1, i));
                end
                if (acc) begin
                    rd("R1 test fmt", fmt(2, n[0], n));
                    for (int i = 0; i < n; i++) rd("R8 test payload", pw(2, i));
                end
                chk("R2 drained", rxne, 0);
                rd("R8 empty read zero", 32'h0);
                chk("R8 empty strobe no move", rx_words, 0);
            end
        end

        // R12: longest encodable frame on an empty FIFO
        flush();
        wr(1'b1, fmt(3, 1'b1, 31));
        chk("R12 oversize rejected", dor, 1);
        chk("R12 level", rx_words, 0);

        // R5 R7: interrupt follows status; ordered clearing
        @(negedge clk);
        chk("R5 doi armed", doi, 1);
        clr_doi = 1'b1; @(negedge clk); clr_doi = 1'b0;
        chk("R7 clear wins over set", doi, 0);
        @(negedge clk);
        chk("R7 re-arm while dor high", doi, 1);
        clr_dor = 1'b1; @(negedge clk); clr_dor = 1'b0;
        chk("R6 dor cleared", dor, 0);
        chk("R7 doi kept by dor clear", doi, 1);
        clr_doi = 1'b1; @(negedge clk); clr_doi = 1'b0;
        chk("R7 doi cleared", doi, 0);
        @(negedge clk);
        chk("R7 doi stays low", doi, 0);
        chk("R6 dor stays low", dor, 0);

        // R6: overrun in the same cycle as the clear command
        wr_valid = 1'b1; wr_first = 1'b1; wr_data = fmt(4, 1'b0, 31); clr_dor = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0; wr_first = 1'b0; clr_dor = 1'b0;
        chk("R6 set beats clear", dor, 1);
        chk("R5 doi one cycle later", doi, 0);
        @(negedge clk);
        chk("R5 doi set", doi, 1);

        // R11: flush empties and clears flags
        wr_frame(5, 2);
        chk("R11 pre level", rx_words, 3);
        flush();
        chk("R11 level", rx_words, 0);
        chk("R11 dor", dor, 0);
        chk("R11 doi", doi, 0);

        // R10: stray words outside a frame
        wr(1'b0, 32'hDEAD_0001);
        wr(1'b0, 32'hDEAD_0002);
        chk("R10 stray ignored", rx_words, 0);
        wr_frame(6, 0);
        chk("R10 next frame level", rx_words, 1);
        rd("R10 next frame data", fmt(6, 1'b0, 0));
        wr(1'b0, 32'hDEAD_0003);
        chk("R10 stray after frame", rx_words, 0);

        // R9: abandoned partial frame, space reclaimed
        flush();
        wr_frame(7, 11);
        chk("R9 fill", rx_words, 12);
        wr(1'b1, fmt(8, 1'b0, 3));
        wr(1'b0, pw(8, 0));
        wr(1'b0, pw(8, 1));
        chk("R9 partial hidden", rx_words, 12);
        wr(1'b1, fmt(9, 1'b1, 3));
        chk("R9 new frame admitted", dor, 0);
        for (int i = 0; i < 3; i++) wr(1'b0, pw(9, i));
        chk("R9 level", rx_words, 16);
        rd("R9 old fmt", fmt(7, 1'b0, 11));
        for (int i = 0; i < 11; i++) rd("R9 old payload", pw(7, i));
        rd("R9 new fmt", fmt(9, 1'b1, 3));
        for (int i = 0; i < 3; i++) rd("R9 new payload", pw(9, i));
        chk("R9 drained", rxne, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule